// File: doc/BRIEF.md
# Oscillator Start-up Timer and Main-Clock Frequency Meter

This block sits in the oscillator control path of a clock controller. When the oscillator enable field is set, it waits out a programmed start-up delay counted in slow-clock cycles. It then declares the main clock usable. The delay is skipped when the bypass field is set, because an external clock on the oscillator input pin then drives the main clock directly.

Once the main clock is declared usable, the block opens a window exactly sixteen slow-clock periods long. A counter running on the main clock counts the main-clock edges that fall inside that window. The count is carried back into the slow domain through a toggle handshake, so the result never shows a partly updated value. The ready status is raised only after this count has arrived. Software reads the count and the ready bit to learn the main-clock frequency relative to the slow clock.

Clearing the enable field or asserting reset drops both flags and zeroes the result.

Top module: `osc_freq_meter`

## Requirements
- R1: With bypass low and a start-up field value N in the range 1 to 255, `mck_valid` first reads high after the slow edge that comes 8×N edges after the first slow edge that samples `osc_en` high. That first sampling edge plus 8×N edges gives 8×N+1 edges in all.
- R2: With bypass high, or with N equal to 0, `mck_valid` reads high after the first slow edge that samples `osc_en` high.
- R3: While `osc_en` is low, `mck_valid` and `freq_ready` are low. On the first slow edge that samples `osc_en` low, `freq_ready` and `mck_valid` fall and `freq_count` becomes zero.
- R4: Once measurement completes, `freq_count` equals the number of main-clock rising edges in 16 slow-clock periods. With the main clock exactly R times faster than the slow clock, this is 16×R.
- R5: `freq_ready` is high only while `mck_valid` is high. `freq_count` reads zero whenever `freq_ready` is low.
- R6: Asserting `rst_n` low drives `mck_valid` and `freq_ready` low and `freq_count` to zero at once, without waiting for a clock edge.
- R7: The start-up field is 8 bits wide. N = 255 gives the longest delay: 2040 cycles, with `mck_valid` first high after 2041 edges.
- R8: The main-domain count reaches the slow domain through a toggle handshake. The value captured is stable whenever the slow side takes it.
- R9: The count saturates at its all-ones value instead of wrapping. A 6-bit instance that sees 64 or more edges reports 63.
- R10: While `osc_en` stays high after `freq_ready` rises, `freq_ready` stays high and `freq_count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slck | input | 1 | Slow reference clock |
| mck | input | 1 | Main clock being started and measured |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| osc_en | input | 1 | Oscillator enable field |
| osc_bypass | input | 1 | Bypass field: external clock, skip start-up delay |
| su_count | input | SU_W (8) | Start-up count, in units of 8 slow cycles |
| mck_valid | output | 1 | Main clock usable (start-up over) |
| freq_ready | output | 1 | Oscillator enabled and frequency result valid |
| freq_count | output | CNT_W (16) | Main-clock edges counted in 16 slow periods, saturating |

## Verification
The assertions take several things for granted:
- The register fields change only on the slow-clock side, and `su_count` and `osc_bypass` are held steady while a start-up or a measurement is running.
- The main clock keeps running whenever `osc_en` is high, so the handshake toggle always comes back.

The stimulus drives all field changes at falling slow edges. It alters the fields only while `osc_en` is low. It changes the main-clock period only while the block is disabled, and it picks integer slow-to-main ratios with a phase offset so that no main edge coincides with a slow edge. With these choices, the expected count of 16×R is exact.

// File: rtl/ofm_pkg.sv
package ofm_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_START  = 3'd1,
    ST_GATE   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_READY  = 3'd4
  } ofm_state_e;

endpackage

// File: rtl/ofm_rst_sync.sv
module ofm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sr_q[STAGES-1];

endmodule

// File: rtl/ofm_seq.sv
module ofm_seq
  import ofm_pkg::*;
#(
  parameter int SU_W       = 8,
  parameter int SU_SCALE   = 8,
  parameter int WIN_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_en,
  input  logic            osc_bypass,
  input  logic [SU_W-1:0] su_count,
  input  logic            res_done,
  output logic            gate_o,
  output logic            valid_o,
  output logic            take_o,
  output logic            clear_o,
  output logic            ready_o
);

  localparam int DLY_W = SU_W + $clog2(SU_SCALE) + 1;
  localparam int WIN_W = $clog2(WIN_CYCLES);

  ofm_state_e       st_q, st_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             gate_q;
  logic             dly_en, win_en;
  logic [DLY_W-1:0] dly_load;

  assign dly_load = DLY_W'(su_count) * DLY_W'(SU_SCALE) - DLY_W'(1);

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    win_d = win_q;
    if (!osc_en) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF: begin
          if (osc_bypass || (su_count == '0)) begin
            st_d  = ST_GATE;
            win_d = WIN_W'(WIN_CYCLES - 1);
          end else begin
            st_d  = ST_START;
            dly_d = dly_load;
          end
        end
        ST_START: begin
          if (dly_q == '0) begin
            st_d  = ST_GATE;
            win_d = WIN_W'(WIN_CYCLES - 1);
          end else begin
            dly_d = dly_q - DLY_W'(1);
          end
        end
        ST_GATE: begin
          if (win_q == '0) st_d = ST_SETTLE;
          else             win_d = win_q - WIN_W'(1);
        end
        ST_SETTLE: begin
          if (res_done) st_d = ST_READY;
        end
        ST_READY: st_d = ST_READY;
        default:  st_d = ST_OFF;
      endcase
    end
  end

  assign dly_en = (st_q == ST_OFF) || (st_q == ST_START);
  assign win_en = (st_d == ST_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      dly_q  <= '0;
      win_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_q <= (st_d == ST_GATE);
      if (dly_en) dly_q <= dly_d;
      if (win_en) win_q <= win_d;
    end
  end

  assign gate_o  = gate_q;
  assign valid_o = (st_q == ST_GATE) || (st_q == ST_SETTLE) || (st_q == ST_READY);
  assign take_o  = (st_q == ST_SETTLE);
  assign clear_o = (st_d == ST_OFF);
  assign ready_o = (st_q == ST_READY);

  // Window-length monitor for the assertion below.
  logic [WIN_W:0] glen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 glen_q <= '0;
    else if ((st_q != ST_GATE) && (st_d == ST_GATE)) glen_q <= '0;
    else if (st_q == ST_GATE)                   glen_q <= glen_q + 1'b1;
  end

  // R4: the gate stays open for exactly WIN_CYCLES slow cycles
  p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE) |-> (glen_q == (WIN_W+1)'(WIN_CYCLES)));

  // R8: the gate drops before the slow side waits for a result
  p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gate_q);

endmodule

// File: rtl/ofm_edge_counter.sv
module ofm_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_async,
  output logic [CNT_W-1:0] hold_o,
  output logic             tog_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             g1_q, gs_q, gd_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q;
  logic             tog_q;
  logic             close_evt;

  assign close_evt = !gs_q && gd_q;

  always_comb begin
    if (gs_q) cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    else      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q   <= 1'b0;
      gs_q   <= 1'b0;
      gd_q   <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      g1_q  <= gate_async;
      gs_q  <= g1_q;
      gd_q  <= gs_q;
      cnt_q <= cnt_d;
      if (close_evt) begin
        hold_q <= cnt_q;
        tog_q  <= ~tog_q;
      end
    end
  end

  assign hold_o = hold_q;
  assign tog_o  = tog_q;

  // R9: a saturated count stays saturated while the gate is open
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_q && (cnt_q == CNT_MAX)) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ofm_result_sync.sv
module ofm_result_sync #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tog_async,
  input  logic [CNT_W-1:0] bus_async,
  input  logic             take,
  input  logic             clear,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o
);

  logic             t1_q, t2_q, t3_q;
  logic             seen;
  logic [CNT_W-1:0] res_q;

  assign seen   = t2_q ^ t3_q;
  assign done_o = take && seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_q  <= 1'b0;
      t2_q  <= 1'b0;
      t3_q  <= 1'b0;
      res_q <= '0;
    end else begin
      t1_q <= tog_async;
      t2_q <= t1_q;
      t3_q <= t2_q;
      if (clear)       res_q <= '0;
      else if (done_o) res_q <= bus_async;
    end
  end

  assign result_o = res_q;

  // R8: the main-domain value is steady when the slow side sees the toggle
  p_bus_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $stable(bus_async));

endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
  import ofm_pkg::*;
#(
  parameter int SU_W       = 8,
  parameter int CNT_W      = 16,
  parameter int SU_SCALE   = 8,
  parameter int WIN_CYCLES = 16
) (
  input  logic             slck,
  input  logic             mck,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             osc_bypass,
  input  logic [SU_W-1:0]  su_count,
  output logic             mck_valid,
  output logic             freq_ready,
  output logic [CNT_W-1:0] freq_count
);

  logic             rst_s_n, rst_m_n;
  logic             gate, take, clear, done;
  logic [CNT_W-1:0] hold;
  logic             tog;

  ofm_rst_sync #(.STAGES(2)) u_rst_s (
    .clk(slck), .arst_n(rst_n), .rst_n_o(rst_s_n));

  ofm_rst_sync #(.STAGES(2)) u_rst_m (
    .clk(mck), .arst_n(rst_n), .rst_n_o(rst_m_n));

  ofm_seq #(
    .SU_W(SU_W), .SU_SCALE(SU_SCALE), .WIN_CYCLES(WIN_CYCLES)
  ) u_seq (
    .clk(slck), .rst_n(rst_s_n),
    .osc_en(osc_en), .osc_bypass(osc_bypass), .su_count(su_count),
    .res_done(done),
    .gate_o(gate), .valid_o(mck_valid), .take_o(take),
    .clear_o(clear), .ready_o(freq_ready));

  ofm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(mck), .rst_n(rst_m_n), .gate_async(gate),
    .hold_o(hold), .tog_o(tog));

  ofm_result_sync #(.CNT_W(CNT_W)) u_res (
    .clk(slck), .rst_n(rst_s_n),
    .tog_async(tog), .bus_async(hold),
    .take(take), .clear(clear),
    .done_o(done), .result_o(freq_count));

  // R3: disable clears everything on the next slow edge
  p_disable_clears_r3: assert property (@(posedge slck) disable iff (!rst_s_n)
    !osc_en |=> (!mck_valid && !freq_ready && (freq_count == '0)));

  // R5: ready implies a usable clock; no count shown before ready
  p_ready_needs_valid_r5: assert property (@(posedge slck) disable iff (!rst_s_n)
    freq_ready |-> mck_valid);

  p_zero_until_ready_r5: assert property (@(posedge slck) disable iff (!rst_s_n)
    !freq_ready |-> (freq_count == '0));

  // R10: result is held while enabled and ready
  p_result_hold_r10: assert property (@(posedge slck) disable iff (!rst_s_n)
    (freq_ready && osc_en) |=> (freq_ready && $stable(freq_count)));

endmodule

// File: tb/osc_freq_meter_test.sv
`timescale 1ps/1ps
module osc_freq_meter_test;

  logic        slck = 1'b0;
  logic        mck  = 1'b0;
  logic        rst_n;
  logic        osc_en;
  logic        osc_bypass;
  logic [7:0]  su_count;
  logic        mck_valid, freq_ready;
  logic [15:0] freq_count;
  logic        nv_valid, nv_ready;
  logic [5:0]  nv_count;

  int mck_half = 500;
  int checks = 0;
  int fails  = 0;

  always #2000 slck = ~slck;
  initial begin
    #137;
    forever #(mck_half) mck = ~mck;
  end

  osc_freq_meter uut (
    .slck(slck), .mck(mck), .rst_n(rst_n),
    .osc_en(osc_en), .osc_bypass(osc_bypass), .su_count(su_count),
    .mck_valid(mck_valid), .freq_ready(freq_ready), .freq_count(freq_count));

  osc_freq_meter #(.CNT_W(6)) uut_narrow (
    .slck(slck), .mck(mck), .rst_n(rst_n),
    .osc_en(osc_en), .osc_bypass(osc_bypass), .su_count(su_count),
    .mck_valid(nv_valid), .freq_ready(nv_ready), .freq_count(nv_count));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int n, input bit byp, input int r);
    int edges;
    int wait_cyc;
    int exp_cnt;
    int exp_nar;
    logic [15:0] snap;
    edges = 0;
    wait_cyc = 0;
    @(negedge slck);
    osc_en = 1'b0;
    mck_half = 2000 / r;
    repeat (6) @(negedge slck);
    su_count   = 8'(n);
    osc_bypass = byp;
    osc_en     = 1'b1;
    while (edges < 3000) begin
      @(posedge slck);
      edges++;
      @(negedge slck);
      if (mck_valid) break;
    end
    if (byp || n == 0) chk("R2 start-up edges", edges, 1);
    else if (n == 255) chk("R7 max start-up edges", edges, 8 * n + 1);
    else               chk("R1 start-up edges", edges, 8 * n + 1);
    chk("R5 not ready at start", int'(freq_ready), 0);
    chk("R5 zero count before ready", int'(freq_count), 0);
    while (!freq_ready && wait_cyc < 200) begin
      @(negedge slck);
      wait_cyc++;
    end
    chk("R5 ready reached", int'(freq_ready), 1);
    exp_cnt = 16 * r;
    exp_nar = (exp_cnt > 63) ? 63 : exp_cnt;
    chk("R4 frequency count", int'(freq_count), exp_cnt);
    repeat (4) @(negedge slck);
    chk("R9 saturating narrow count", int'(nv_count), exp_nar);
    snap = freq_count;
    repeat (5) @(negedge slck);
    chk("R10 ready held", int'(freq_ready), 1);
    chk("R10 count held", int'(freq_count), int'(snap));
    osc_en = 1'b0;
    @(posedge slck);
    @(negedge slck);
    chk("R3 ready cleared", int'(freq_ready), 0);
    chk("R3 valid cleared", int'(mck_valid), 0);
    chk("R3 count cleared", int'(freq_count), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    osc_en = 1'b0;
    osc_bypass = 1'b0;
    su_count = '0;
    #1;
    chk("R6 reset valid", int'(mck_valid), 0);
    chk("R6 reset ready", int'(freq_ready), 0);
    chk("R6 reset count", int'(freq_count), 0);
    repeat (4) @(negedge slck);
    rst_n = 1'b1;
    repeat (4) @(negedge slck);
    chk("R3 idle while disabled", int'(mck_valid), 0);

    foreach (rlist[i]) begin end
    for (int ri = 0; ri < 4; ri++) begin
      for (int ni = 0; ni < 3; ni++) begin
        for (int b = 0; b < 2; b++) begin
          run_case(nlist[ni], b[0], rlist[ri]);
        end
      end
    end
    run_case(255, 1'b0, 4);

    // R6: asynchronous reset in the middle of a finished measurement
    run_case_partial();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  int rlist[4] = '{2, 4, 5, 8};
  int nlist[3] = '{0, 1, 3};

  task automatic run_case_partial();
    int wait_cyc;
    wait_cyc = 0;
    @(negedge slck);
    mck_half = 500;
    su_count = 8'd0;
    osc_bypass = 1'b1;
    osc_en = 1'b1;
    while (!freq_ready && wait_cyc < 200) begin
      @(negedge slck);
      wait_cyc++;
    end
    chk("R4 count before reset", int'(freq_count), 64);
    #500;
    rst_n = 1'b0;
    #1;
    chk("R6 async valid", int'(mck_valid), 0);
    chk("R6 async ready", int'(freq_ready), 0);
    chk("R6 async count", int'(freq_count), 0);
    osc_en = 1'b0;
    repeat (3) @(negedge slck);
    rst_n = 1'b1;
    repeat (3) @(negedge slck);
  endtask

  initial begin
    #400_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule